// File: doc/BRIEF.md
# Accumulator CPU Sequencer

This block is the control path and register set of a small single-accumulator processor. Every instruction runs a shared four-clock fetch, then an execute sequence chosen by the opcode. Each clock makes one register transfer between the program counter, the memory address register (MAR), the memory buffer register (MBR), the instruction register and the accumulator D0. Arithmetic results also set a four-bit condition code (carry, zero, negative, overflow), which the conditional branches test.

A single synchronous memory port serves both instructions and data. The address output is always the MAR. Read data arrives one clock after an address is presented, so every read has a wait clock before the MBR captures the word. Writes take one clock and happen on the address held in the MAR. The integrating system puts a memory behind the port, loads a program while reset is held, and then releases reset. Execution starts at address 0 and runs until a halt instruction.

Top module: `accu_cpu`

## Requirements
- R1: A synchronous active-low reset clears the program counter, MAR, MBR, instruction register, D0 and the condition code. The cycle after reset presents address 0, with write enable low and `halted` low. D0 holds zero when the first instruction executes.
- R2: Fetch takes four clocks, in this order:
  - the MAR takes the program counter;
  - the program counter increments while the memory read is in flight;
  - the MBR captures the read data;
  - the instruction register takes the MBR.
- R3: An instruction word carries the opcode in bits 15..12 and the address in bits 11..0. The opcodes are:
  - 0 = halt;
  - 1 = load;
  - 2 = store;
  - 3 = add;
  - 4 = subtract;
  - 5 = jump;
  - 6 and 7 = no operation;
  - 8..15 = conditional branch.
- R4: Load takes four execute clocks: MAR from the address field, a wait clock, MBR from memory, then D0 from the low 8 bits of the MBR. It leaves the condition code unchanged.
- R5: Add and subtract take four execute clocks, laid out like load. The last clock writes D0 with D0 plus or minus the operand and updates the flags:
  - Z is set when the result is zero;
  - N is the result's top bit;
  - C is the carry out for add and the borrow (D0 below operand, unsigned) for subtract;
  - V is signed overflow.
- R6: Store takes three execute clocks: MAR from the address field, MBR from D0, then a single write clock. That clock asserts `mem_we` with `mem_wdata` = {8'h00, D0} at the MAR address.
- R7: Jump takes one execute clock and always loads the program counter from the address field. A branch (opcode 1ccc) takes one execute clock and loads the program counter from the address field only when its condition holds. Otherwise the already-incremented value stays. The condition codes are:
  - ccc=0: Z set;
  - ccc=1: Z clear;
  - ccc=2: C set;
  - ccc=3: C clear;
  - ccc=4: N set;
  - ccc=5: N clear;
  - ccc=6: V set;
  - ccc=7: V clear.
  
  No-operation opcodes take one execute clock.
- R8: Halt takes one execute clock, then `halted` goes high and stays high until reset. While halted, no write occurs and the address does not change.
- R9: The instruction sequence load Q, add R, store P, halt raises `halted` after 28 clock edges with reset deasserted, and leaves P = Q + R in memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 12 | Memory address, driven from the MAR |
| mem_wdata | output | 16 | Memory write data, driven from the MBR |
| mem_we | output | 1 | Memory write enable for one clock |
| mem_rdata | input | 16 | Synchronous read data, valid one clock after the address |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
Two pairs of actions share a clock in this design.

- In the last execute step, D0 is written, and for arithmetic the flags are written in the same clock. A load performs the same D0 write but must not touch the flags. The bench places a load between a subtraction that yields zero and a branch on Z set, so the branch is taken only if the load left Z alone.
- In the second fetch clock, the program counter increments while the instruction read is in flight. A taken branch later overwrites that incremented value.

Both cases are judged by a behavioural reference model compared on every clock. It checks the address, write strobe, write data and halt flag, so a wrong branch shows up as a wrong fetch address within one clock.

// File: rtl/accu_pkg.sv
// Package: shared opcode values, sequencer states, flag and control bundles.
// Assumes a 4-bit opcode in the top bits of the instruction word.
package accu_pkg;

    localparam int OP_W = 4;

    localparam logic [OP_W-1:0] OP_HALT  = 4'd0;
    localparam logic [OP_W-1:0] OP_LOAD  = 4'd1;
    localparam logic [OP_W-1:0] OP_STORE = 4'd2;
    localparam logic [OP_W-1:0] OP_ADD   = 4'd3;
    localparam logic [OP_W-1:0] OP_SUB   = 4'd4;
    localparam logic [OP_W-1:0] OP_JUMP  = 4'd5;

    // One-transfer-per-clock sequencer steps
    typedef enum logic [3:0] {
        ST_F_ADDR,   // MAR <- PC
        ST_F_WAIT,   // PC <- PC + 1, read in flight
        ST_F_CAPT,   // MBR <- memory
        ST_F_IR,     // IR <- MBR
        ST_X1,
        ST_X2,
        ST_X3,
        ST_X4,
        ST_STOP
    } seq_state_t;

    typedef struct packed {
        logic c;
        logic z;
        logic n;
        logic v;
    } ccr_t;

    // Register transfer strobes issued by the sequencer
    typedef struct packed {
        logic mar_from_pc;
        logic mar_from_ir;
        logic pc_inc;
        logic pc_from_ir;
        logic mbr_from_mem;
        logic mbr_from_acc;
        logic ir_load;
        logic acc_from_mbr;
        logic acc_from_alu;
        logic alu_sub;
        logic mem_write;
    } ctl_t;

    // True for opcodes whose execute sequence goes through MAR/MBR
    function automatic logic uses_operand(input logic [OP_W-1:0] op);
        return (op == OP_LOAD) || (op == OP_STORE) || (op == OP_ADD) || (op == OP_SUB);
    endfunction

    // True for the conditional branch group (top opcode bit set)
    function automatic logic is_branch(input logic [OP_W-1:0] op);
        return op[OP_W-1];
    endfunction

endpackage

// File: rtl/accu_alu.sv
// Module: accu_alu
// Adds or subtracts two DATA_W-bit operands and produces the four flags.
// Assumes C means carry for add and borrow for subtract; purely combinational.
module accu_alu #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    output logic [DATA_W-1:0] result,
    output accu_pkg::ccr_t    flags
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W:0] wide;

    // Extended-width sum or difference; the extra bit is carry or borrow
    always_comb begin
        if (sub) begin
            wide = {1'b0, a} - {1'b0, b};
        end else begin
            wide = {1'b0, a} + {1'b0, b};
        end
    end

    assign result = wide[DATA_W-1:0];

    // Flag derivation from operands and result
    always_comb begin
        flags.c = wide[DATA_W];
        flags.z = (wide[DATA_W-1:0] == '0);
        flags.n = wide[MSB];
        if (sub) begin
            flags.v = (a[MSB] != b[MSB]) && (wide[MSB] != a[MSB]);
        end else begin
            flags.v = (a[MSB] == b[MSB]) && (wide[MSB] != a[MSB]);
        end
    end

endmodule

// File: rtl/accu_cond.sv
// Module: accu_cond
// Evaluates a 3-bit branch condition against the condition code.
// Assumes even codes test a flag set and odd codes test it clear (Z, C, N, V).
module accu_cond (
    input  accu_pkg::ccr_t ccr,
    input  logic [2:0]     sel,
    output logic           taken
);
    logic flag_bit;

    // Pick the tested flag from the upper two select bits
    always_comb begin
        unique case (sel[2:1])
            2'd0: flag_bit = ccr.z;
            2'd1: flag_bit = ccr.c;
            2'd2: flag_bit = ccr.n;
            default: flag_bit = ccr.v;
        endcase
    end

    // Low select bit inverts the sense
    assign taken = flag_bit ^ sel[0];

endmodule

// File: rtl/accu_ctrl.sv
// Module: accu_ctrl
// Sequencer: shared fetch steps, then per-opcode execute steps.
// It issues one set of transfer strobes per clock.
// Assumes the opcode input is the instruction register field, valid from ST_X1 on.
module accu_ctrl
    import accu_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [OP_W-1:0]    op,
    input  logic               taken,
    output seq_state_t         state,
    output ctl_t               ctl
);
    seq_state_t nxt;

    // State register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_F_ADDR;
        end else begin
            state <= nxt;
        end
    end

    // Next-step selection
    always_comb begin
        nxt = state;
        unique case (state)
            ST_F_ADDR: nxt = ST_F_WAIT;
            ST_F_WAIT: nxt = ST_F_CAPT;
            ST_F_CAPT: nxt = ST_F_IR;
            ST_F_IR:   nxt = ST_X1;
            ST_X1: begin
                if (op == OP_HALT) begin
                    nxt = ST_STOP;
                end else if (uses_operand(op)) begin
                    nxt = ST_X2;
                end else begin
                    nxt = ST_F_ADDR;
                end
            end
            ST_X2:   nxt = ST_X3;
            ST_X3:   nxt = (op == OP_STORE) ? ST_F_ADDR : ST_X4;
            ST_X4:   nxt = ST_F_ADDR;
            ST_STOP: nxt = ST_STOP;
            default: nxt = ST_F_ADDR;
        endcase
    end

    // Transfer strobes for the current step
    always_comb begin
        ctl = '0;
        unique case (state)
            ST_F_ADDR: ctl.mar_from_pc  = 1'b1;
            ST_F_WAIT: ctl.pc_inc       = 1'b1;
            ST_F_CAPT: ctl.mbr_from_mem = 1'b1;
            ST_F_IR:   ctl.ir_load      = 1'b1;
            ST_X1: begin
                ctl.mar_from_ir = uses_operand(op);
                ctl.pc_from_ir  = (op == OP_JUMP) || (is_branch(op) && taken);
            end
            ST_X2: ctl.mbr_from_acc = (op == OP_STORE);
            ST_X3: begin
                ctl.mem_write    = (op == OP_STORE);
                ctl.mbr_from_mem = (op != OP_STORE);
            end
            ST_X4: begin
                ctl.acc_from_mbr = (op == OP_LOAD);
                ctl.acc_from_alu = (op == OP_ADD) || (op == OP_SUB);
                ctl.alu_sub      = (op == OP_SUB);
            end
            default: ctl = '0;
        endcase
    end

endmodule

// File: rtl/accu_dpath.sv
// Module: accu_dpath
// Register set PC, MAR, MBR, IR, D0 and condition code, with the ALU and
// branch condition logic. It applies the strobes it receives.
// Assumes DATA_W is below the word width, so D0 is zero-extended into the MBR.
module accu_dpath
    import accu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  ctl_t                     ctl,
    input  logic [OP_W+ADDR_W-1:0]   mem_rdata,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic [OP_W+ADDR_W-1:0]   mem_wdata,
    output logic [OP_W-1:0]          op,
    output logic                     taken,
    output logic [ADDR_W-1:0]        pc
);
    localparam int WORD_W = OP_W + ADDR_W;

    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] mar_q;
    logic [WORD_W-1:0] mbr_q;
    logic [WORD_W-1:0] ir_q;
    logic [DATA_W-1:0] acc_q;
    ccr_t              ccr_q;
    logic [DATA_W-1:0] alu_res;
    ccr_t              alu_flags;
    logic [ADDR_W-1:0] ir_addr;

    assign ir_addr = ir_q[ADDR_W-1:0];
    assign op      = ir_q[WORD_W-1 -: OP_W];

    // Program counter: jump target has priority over increment
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else if (ctl.pc_from_ir) begin
            pc_q <= ir_addr;
        end else if (ctl.pc_inc) begin
            pc_q <= pc_q + 1'b1;
        end
    end

    // Memory address register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mar_q <= '0;
        end else if (ctl.mar_from_pc) begin
            mar_q <= pc_q;
        end else if (ctl.mar_from_ir) begin
            mar_q <= ir_addr;
        end
    end

    // Memory buffer register: memory word or zero-extended accumulator
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mbr_q <= '0;
        end else if (ctl.mbr_from_mem) begin
            mbr_q <= mem_rdata;
        end else if (ctl.mbr_from_acc) begin
            mbr_q <= WORD_W'(acc_q);
        end
    end

    // Instruction register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q <= '0;
        end else if (ctl.ir_load) begin
            ir_q <= mbr_q;
        end
    end

    // Accumulator D0
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (ctl.acc_from_alu) begin
            acc_q <= alu_res;
        end else if (ctl.acc_from_mbr) begin
            acc_q <= mbr_q[DATA_W-1:0];
        end
    end

    // Condition code: written only by arithmetic results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ccr_q <= '0;
        end else if (ctl.acc_from_alu) begin
            ccr_q <= alu_flags;
        end
    end

    accu_alu #(
        .DATA_W (DATA_W)
    ) u_alu (
        .a      (acc_q),
        .b      (mbr_q[DATA_W-1:0]),
        .sub    (ctl.alu_sub),
        .result (alu_res),
        .flags  (alu_flags)
    );

    accu_cond u_cond (
        .ccr   (ccr_q),
        .sel   (op[2:0]),
        .taken (taken)
    );

    assign mem_addr  = mar_q;
    assign mem_wdata = mbr_q;
    assign pc        = pc_q;

endmodule

// File: rtl/accu_cpu.sv
// Module: accu_cpu (top)
// Accumulator processor: sequencer plus register set on one shared
// synchronous memory port.
// Assumes memory returns read data one clock after the address and writes
// on the clock where mem_we is high.
module accu_cpu
    import accu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    output logic [ADDR_W-1:0]      mem_addr,
    output logic [OP_W+ADDR_W-1:0] mem_wdata,
    output logic                   mem_we,
    input  logic [OP_W+ADDR_W-1:0] mem_rdata,
    output logic                   halted
);
    seq_state_t        state;
    ctl_t              ctl;
    logic [OP_W-1:0]   op;
    logic              taken;
    logic [ADDR_W-1:0] pc_q;

    accu_ctrl u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (op),
        .taken (taken),
        .state (state),
        .ctl   (ctl)
    );

    accu_dpath #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_dpath (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .op        (op),
        .taken     (taken),
        .pc        (pc_q)
    );

    assign mem_we = ctl.mem_write;
    assign halted = (state == ST_STOP);

endmodule

// File: rtl/accu_cpu_chk.sv
// Module: accu_cpu_chk
// Temporal checks on the port and sequencer state, bound into accu_cpu.
// Assumes synchronous active-low reset; all properties are disabled in reset.
module accu_cpu_chk
    import accu_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_we,
    input logic              halted,
    input logic [ADDR_W-1:0] pc,
    input seq_state_t        st
);
    AST_MAR_TAKES_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_F_ADDR) |=> (mem_addr == $past(pc)));                  // R2
    AST_PC_STEPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_F_WAIT) |=> (pc == ADDR_W'($past(pc) + 1'b1)));        // R2
    AST_WRITE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);                                              // R6
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && !mem_we));                                  // R8
    AST_HALT_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(mem_addr));                                    // R8
    AST_HALT_PC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(pc));                                          // R8

endmodule

bind accu_cpu accu_cpu_chk #(
    .ADDR_W (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_addr (mem_addr),
    .mem_we   (mem_we),
    .halted   (halted),
    .pc       (pc_q),
    .st       (state)
);

// File: tb/accu_cpu_test.sv
// Bench for accu_cpu: 256-word synchronous memory, a behavioural reference
// model stepped once per clock and compared at every falling edge.
module accu_cpu_test;

    localparam int DW = 8;
    localparam int AW = 12;
    localparam int WW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [WW-1:0] mem_wdata;
    logic [WW-1:0] mem_rdata;
    logic          mem_we;
    logic          halted;

    always #5 clk = ~clk;

    accu_cpu #(.DATA_W(DW), .ADDR_W(AW)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_rdata (mem_rdata),
        .halted    (halted)
    );

    // Memory attached to the port: registered read, write on mem_we
    logic [WW-1:0] ram [256];
    always @(posedge clk) begin
        mem_rdata <= ram[mem_addr[7:0]];
        if (mem_we) ram[mem_addr[7:0]] = mem_wdata;
    end

    int n_cmp = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    int ref_mem [256];
    int m_pc, m_mar, m_mbr, m_ir, m_acc, m_rd, m_ph;
    bit m_c, m_z, m_n, m_v;
    bit armed = 1'b0;
    int cyc = 0;
    int first_halt = -1;
    int m_op, m_ad, rd_new, sa, sb, sr;
    bit exp_we;
    string rq;

    function automatic bit cond_ok(input int sel);
        case (sel)
            0: return m_z;
            1: return !m_z;
            2: return m_c;
            3: return !m_c;
            4: return m_n;
            5: return !m_n;
            6: return m_v;
            default: return !m_v;
        endcase
    endfunction

    function automatic string req_of(input int ph, input int op);
        if (ph == 99) return "R8";
        if (ph < 4) return "R2";
        if (op == 1) return "R4";
        if (op == 3 || op == 4) return "R5";
        if (op == 2) return "R6";
        if (op == 0) return "R8";
        return "R7";
    endfunction

    always @(negedge clk) begin
        if (!rst_n) begin
            m_pc = 0; m_mar = 0; m_mbr = 0; m_ir = 0; m_acc = 0; m_ph = 0;
            m_c = 0; m_z = 0; m_n = 0; m_v = 0;
            m_rd = ref_mem[0];
            armed = 1'b1;
            cyc = 0;
            first_halt = -1;
        end else if (armed) begin
            m_op = m_ir >> 12;
            m_ad = m_ir & 'hFFF;
            exp_we = (m_ph == 12) && (m_op == 2);
            rq = (cyc == 0) ? "R1" : req_of(m_ph, m_op);
            chk(int'(mem_addr) == m_mar, rq, "mem_addr", int'(mem_addr), m_mar);
            chk(mem_we == exp_we, rq, "mem_we", int'(mem_we), int'(exp_we));
            chk(halted == (m_ph == 99), rq, "halted", int'(halted), int'(m_ph == 99));
            if (exp_we) chk(int'(mem_wdata) == m_mbr, rq, "mem_wdata", int'(mem_wdata), m_mbr);
            if (halted && first_halt < 0) first_halt = cyc;
            cyc++;
            // advance to the state after the next rising edge
            rd_new = ref_mem[m_mar & 255];
            if (exp_we) ref_mem[m_mar & 255] = m_mbr;
            case (m_ph)
                0: begin m_mar = m_pc; m_ph = 1; end
                1: begin m_pc = (m_pc + 1) & 'hFFF; m_ph = 2; end
                2: begin m_mbr = m_rd; m_ph = 3; end
                3: begin m_ir = m_mbr; m_ph = 10; end
                10: begin
                    if (m_op == 0) m_ph = 99;
                    else if (m_op >= 1 && m_op <= 4) begin m_mar = m_ad; m_ph = 11; end
                    else begin
                        if (m_op == 5 || (m_op >= 8 && cond_ok(m_op & 7))) m_pc = m_ad;
                        m_ph = 0;
                    end
                end
                11: begin
                    if (m_op == 2) m_mbr = m_acc;
                    m_ph = 12;
                end
                12: begin
                    if (m_op == 2) m_ph = 0;
                    else begin m_mbr = m_rd; m_ph = 13; end
                end
                13: begin
                    sa = m_acc; sb = m_mbr & 255;
                    if (m_op == 1) m_acc = sb;
                    else begin
                        if (m_op == 3) begin
                            sr = sa + sb; m_c = (sr > 255); sr = sr & 255;
                            m_v = (((sa ^ sr) & (sb ^ sr) & 128) != 0);
                        end else begin
                            m_c = (sa < sb); sr = (sa - sb) & 255;
                            m_v = (((sa ^ sb) & (sa ^ sr) & 128) != 0);
                        end
                        m_z = (sr == 0); m_n = (sr >= 128); m_acc = sr;
                    end
                    m_ph = 0;
                end
                default: m_ph = 99;
            endcase
            m_rd = rd_new;
        end
    end

    // ---------------- stimulus helpers ----------------
    function automatic int enc(input int op, input int ad);
        return (op << 12) | ad;
    endfunction

    task automatic poke(input int ad, input int val);
        ram[ad] = WW'(val);
        ref_mem[ad] = val;
    endtask

    task automatic begin_reset();
        @(posedge clk);
        #1 rst_n = 1'b0;
        for (int i = 0; i < 256; i++) poke(i, 0);
    endtask

    task automatic go(input int exp_cyc);
        int n;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        n = 0;
        while (!halted && n < 2000) begin
            @(negedge clk);
            n++;
        end
        if (!halted) chk(1'b0, "R8", "watchdog, halted never rose", 0, 1);
        repeat (4) @(posedge clk);
        #1 chk(first_halt == exp_cyc, "R9", "clocks until halted", first_halt, exp_cyc);
    endtask

    // global watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // Program 1: P = Q + R (R9, R3)
        begin_reset();
        poke(0, enc(1, 'h40)); poke(1, enc(3, 'h41)); poke(2, enc(2, 'h42)); poke(3, enc(0, 0));
        poke('h40, 'h25); poke('h41, 'h3A);
        go(28);
        chk(ram['h42] == 16'h005F, "R3", "P = Q + R", int'(ram['h42]), 'h5F);
        chk(ram['h40] == 16'h0025, "R4", "operand Q untouched", int'(ram['h40]), 'h25);

        // Program 2: flags, every branch sense, load keeps flags (R4, R5, R7)
        begin_reset();
        poke(0, enc(1, 'h80));  poke(1, enc(3, 'h81));  poke(2, enc('hE, 4));
        poke(4, enc('hA, 3));   poke(5, enc(4, 'h82));  poke(6, enc(9, 3));
        poke(7, enc(1, 'h81));  poke(8, enc(8, 10));    poke(10, enc(2, 'h90));
        poke(11, enc(1, 'h83)); poke(12, enc(4, 'h81)); poke(13, enc('hB, 3));
        poke(14, enc('hC, 16)); poke(16, enc('hD, 3));  poke(17, enc('hF, 19));
        poke(19, enc(2, 'h91)); poke(20, enc(5, 22));   poke(22, enc(6, 0));
        poke('h80, 'h7F); poke('h81, 'h01); poke('h82, 'h80); poke('h83, 'h00);
        go(117);
        chk(ram['h90] == 16'h0001, "R4", "load kept Z for branch", int'(ram['h90]), 1);
        chk(ram['h91] == 16'h00FF, "R7", "branch path store", int'(ram['h91]), 'hFF);

        // Program 3: D0 cleared by reset, carry and subtract overflow (R1, R5)
        begin_reset();
        poke(0, enc(3, 'hA0)); poke(1, enc(3, 'hA1)); poke(2, enc('hA, 4));
        poke(4, enc(1, 'hA2)); poke(5, enc(4, 'hA3)); poke(6, enc('hF, 3));
        poke(7, enc('hD, 9));  poke(9, enc(2, 'hA4));
        poke('hA0, 'hF0); poke('hA1, 'h20); poke('hA2, 'h80); poke('hA3, 'h01);
        go(59);
        chk(ram['hA4] == 16'h007F, "R5", "overflowing subtract result", int'(ram['hA4]), 'h7F);
        chk(halted == 1'b1, "R8", "halted held", int'(halted), 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule